// File: doc/BRIEF.md
# Display-Side Link Write Receiver and Panel Bus Strobe Sequencer

This block sits at the display end of a two-lane, double-data-rate serial link. While the link is idle it watches lane 0 for a start bit. When one arrives it captures a five-cycle write frame and rebuilds the frame as a 16-bit word. The word carries an address/data flag and a select bit that names one of two panels. Each word goes into a short queue. It is then replayed on a parallel panel bus with fixed timing, counted in link clock cycles. The width of the host's own strobe has no effect on this timing.

The panel bus can run in an i80-style mode, with separate write and read strobes, or in an m68-style mode, where the chip select is the strobe and there is an enable pin and a read/write pin. The mode is set here and does not have to match the host side. Frames may follow one another with no idle cycle between them. A frame that asks for a read is kept off the write path and is reported on a separate request output. When the power-down input is low, every panel output is held at a fixed level that depends on the mode, and the internal state is cleared.

Top module: `slv_frame_rx`

## Requirements
- R1: After reset, and whenever no word is being replayed, both chip selects, MF0 and MF1 are high, the data bus value is 0 and its drive enable is 0.
- R2: A frame starts when lane 0 is 1 in the rising half of a cycle during idle. Frame layout:
  - Header cycle: lane 1 carries the read/write bit in the rising half and the select bit in the falling half. Lane 0 carries the address/data flag in the falling half.
  - Four data cycles: lane 0 carries bits 0 to 7 and lane 1 carries bits 8 to 15, least significant bit first, the rising-half bit ahead of the falling-half bit.
  - The replayed word equals the sent word.
- R3: The panel strobe stays low for exactly 3 link cycles for every word.
- R4: Data is driven from 1 cycle before the strobe falls until 1 cycle after it rises, and is released (enable 0, value 0) once that hold cycle ends. With the start bit sampled at edge S, the drive window spans the cycles after edges S+6 to S+10.
- R5: In i80 mode (modeI80=1), MF1 is the active-low write strobe, MF0 (read strobe) stays high, and the selected chip select is low for the whole drive window.
- R6: In m68 mode (modeI80=0), the selected chip select is the strobe, MF0 (enable) stays high, and MF1 (read/write) is low for the whole drive window.
- R7: A select bit of 1 targets CS1 and a select bit of 0 targets CS2. The other select stays high. The address/data output equals the received flag.
- R8: While pdN is 0, the outputs hold these levels:
  - busAd is 1, busData is 0 with its enable at 1, and clkOut is 0.
  - busCs1N, busMf0 and busMf1 are all 1.
  - busCs2N is 0 in i80 mode and 1 in m68 mode.
  - When pdN is 1, clkOut follows refClkIn.
- R9: Frames sent back to back are all replayed, in order, each drive window starting right after the previous one ends.
- R10: A frame whose read/write bit is 1 causes no panel bus activity. One cycle after its header, readReq pulses for one cycle and carries the flag and the select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; lanes sampled on both edges |
| rstN | input | 1 | Asynchronous active-low reset |
| pdN | input | 1 | Active-low power-down; clears state and forces safe levels |
| modeI80 | input | 1 | 1 = i80-style panel bus, 0 = m68-style |
| laneIn | input | 2 | Serial data lanes (bit 0 = lane 0) |
| refClkIn | input | 1 | Reference clock to be passed to the panel |
| busAd | output | 1 | Address/data select to panel (1 = data) |
| busData | output | 16 | Panel data bus value |
| busDataOe | output | 1 | Drive enable for busData |
| busCs1N | output | 1 | Chip select 1, active low |
| busCs2N | output | 1 | Chip select 2, active low |
| busMf0 | output | 1 | Read strobe (i80) or enable (m68) |
| busMf1 | output | 1 | Write strobe (i80) or read/write (m68) |
| clkOut | output | 1 | Reference clock out, low in power-down |
| readReq | output | 1 | One-cycle pulse for a received read header |
| readAd | output | 1 | Address/data flag of that read header |
| readToCs1 | output | 1 | Select bit of that read header |

## Verification
The hardest case is back-to-back frames. Here the next start bit sits in the rising half right after the previous frame's last falling-half bit. The second frame is being deserialized while the first word is still being replayed, and the queue's pop happens on the very edge the previous hold cycle ends. The bench drives three frames with no idle cycle between them and checks every replayed word cycle by cycle against the start edge of its own frame. This also proves that the drive windows abut with no gap. Power-down is applied while the panel bus is idle, in both modes, and a write afterwards confirms the state came back clean.

// File: rtl/slv_wr_pkg.sv
package slv_wr_pkg;
  localparam int LANES     = 2;
  localparam int LANE_BITS = 8;
  localparam int WORD_W    = LANES * LANE_BITS;

  typedef struct packed {
    logic              ad;
    logic              toCs1;
    logic [WORD_W-1:0] data;
  } wr_word_t;

  typedef struct packed {
    logic capHdr;
    logic capData;
    logic push;
    logic pop;
    logic busActive;
    logic busStrobe;
    logic readPulse;
  } ctrl_t;
endpackage

// File: rtl/slv_wr_ctrl.sv
module slv_wr_ctrl
  import slv_wr_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int LOW_CYC   = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdN,
  input  logic [LANES-1:0] pairRise,
  input  logic             qEmpty,
  output ctrl_t            ctl
);
  localparam int DATA_PAIRS = LANE_BITS / 2;
  localparam int TOTAL      = SETUP_CYC + LOW_CYC + HOLD_CYC;
  localparam int PH_W       = $clog2(TOTAL + 1);
  localparam int CNT_W      = (DATA_PAIRS > 1) ? $clog2(DATA_PAIRS) : 1;
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(TOTAL - 1);
  localparam logic [PH_W-1:0]  PH_LOW0   = PH_W'(SETUP_CYC);
  localparam logic [PH_W-1:0]  PH_LOWEND = PH_W'(SETUP_CYC + LOW_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(DATA_PAIRS - 1);

  typedef enum logic {RX_IDLE, RX_DATA} rx_state_t;

  rx_state_t        rxState;
  logic [CNT_W-1:0] pairCnt;
  logic             busOn;
  logic [PH_W-1:0]  ph;
  logic             lastPh;

  always_comb begin
    lastPh        = busOn && (ph == PH_LAST);
    ctl.capHdr    = pdN && (rxState == RX_IDLE) && pairRise[0];
    ctl.readPulse = ctl.capHdr && pairRise[1];
    ctl.capData   = pdN && (rxState == RX_DATA);
    ctl.push      = ctl.capData && (pairCnt == CNT_LAST);
    ctl.pop       = pdN && (!busOn || lastPh) && !qEmpty;
    ctl.busActive = busOn;
    ctl.busStrobe = busOn && (ph >= PH_LOW0) && (ph < PH_LOWEND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      pairCnt <= '0;
      busOn   <= 1'b0;
      ph      <= '0;
    end else if (!pdN) begin
      rxState <= RX_IDLE;
      pairCnt <= '0;
      busOn   <= 1'b0;
      ph      <= '0;
    end else begin
      case (rxState)
        RX_IDLE: if (ctl.capHdr && !pairRise[1]) begin
          rxState <= RX_DATA;
          pairCnt <= '0;
        end
        default: if (ctl.push) rxState <= RX_IDLE;
                 else pairCnt <= pairCnt + 1'b1;
      endcase
      if (ctl.pop) begin
        busOn <= 1'b1;
        ph    <= '0;
      end else if (lastPh) begin
        busOn <= 1'b0;
      end else if (busOn) begin
        ph <= ph + 1'b1;
      end
    end
  end

  // Run length of the current strobe-low stretch, kept for the width check.
  logic [PH_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowRun <= '0;
    else if (!pdN)          lowRun <= '0;
    else if (ctl.busStrobe) lowRun <= lowRun + 1'b1;
    else                    lowRun <= '0;
  end

  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rstN || !pdN)
    $fell(ctl.busStrobe) |-> (lowRun == PH_W'(LOW_CYC)));

  a_r4_setup_first: assert property (@(posedge clk) disable iff (!rstN || !pdN)
    $rose(ctl.busStrobe) |-> $past(ctl.busActive));

  a_r4_hold_after: assert property (@(posedge clk) disable iff (!rstN || !pdN)
    $fell(ctl.busStrobe) |-> ctl.busActive);
endmodule

// File: rtl/slv_wr_dp.sv
module slv_wr_dp
  import slv_wr_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdN,
  input  logic              modeI80,
  input  logic [LANES-1:0]  laneIn,
  input  logic              refClkIn,
  input  ctrl_t             ctl,
  output logic [LANES-1:0]  pairRise,
  output logic              qEmpty,
  output logic [WORD_W-1:0] busData,
  output logic              busAd,
  output logic              busDataOe,
  output logic              busCs1N,
  output logic              busCs2N,
  output logic              busMf0,
  output logic              busMf1,
  output logic              clkOut,
  output logic              readReq,
  output logic              readAd,
  output logic              readToCs1
);
  localparam int PW  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW  = $clog2(QDEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(QDEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(QDEPTH);

  logic [LANES-1:0] riseReg, fallReg;
  logic [LANES-1:0][LANE_BITS-1:0] laneByte, nextByte;
  logic hdrAd, hdrSel;
  wr_word_t newWord, curWord;
  wr_word_t qMem [QDEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] qCount;
  logic qFull;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) riseReg <= '0; else riseReg <= laneIn;
  always_ff @(negedge clk or negedge rstN)
    if (!rstN) fallReg <= '0; else fallReg <= laneIn;

  assign pairRise = riseReg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign nextByte[g] = {fallReg[g], riseReg[g], laneByte[g][LANE_BITS-1:2]};
  end

  assign newWord = '{ad: hdrAd, toCs1: hdrSel, data: nextByte};
  assign qEmpty  = (qCount == '0);
  assign qFull   = (qCount == CNT_FULL);

  always_ff @(posedge clk) if (ctl.push) qMem[wrPtr] <= newWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneByte <= '0; hdrAd <= 1'b0; hdrSel <= 1'b0;
      wrPtr <= '0; rdPtr <= '0; qCount <= '0; curWord <= '0;
      readReq <= 1'b0; readAd <= 1'b0; readToCs1 <= 1'b0;
    end else if (!pdN) begin
      laneByte <= '0; hdrAd <= 1'b0; hdrSel <= 1'b0;
      wrPtr <= '0; rdPtr <= '0; qCount <= '0; curWord <= '0;
      readReq <= 1'b0; readAd <= 1'b0; readToCs1 <= 1'b0;
    end else begin
      if (ctl.capHdr) begin
        hdrAd  <= fallReg[0];
        hdrSel <= fallReg[1];
      end
      if (ctl.capData) laneByte <= nextByte;
      if (ctl.push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (ctl.pop) begin
        curWord <= qMem[rdPtr];
        rdPtr   <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      end
      qCount    <= qCount + CW'(ctl.push) - CW'(ctl.pop);
      readReq   <= ctl.readPulse;
      readAd    <= fallReg[0];
      readToCs1 <= fallReg[1];
    end
  end

  always_comb begin
    clkOut = refClkIn & pdN;
    if (!pdN) begin
      busAd = 1'b1; busData = '0; busDataOe = 1'b1;
      busCs1N = 1'b1; busCs2N = !modeI80; busMf0 = 1'b1; busMf1 = 1'b1;
    end else begin
      busAd     = curWord.ad;
      busData   = ctl.busActive ? curWord.data : '0;
      busDataOe = ctl.busActive;
      busMf0    = 1'b1;
      if (modeI80) begin
        busMf1  = !ctl.busStrobe;
        busCs1N = !(ctl.busActive && curWord.toCs1);
        busCs2N = !(ctl.busActive && !curWord.toCs1);
      end else begin
        busMf1  = !ctl.busActive;
        busCs1N = !(ctl.busStrobe && curWord.toCs1);
        busCs2N = !(ctl.busStrobe && !curWord.toCs1);
      end
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN || !pdN)
    ctl.push |-> !qFull);

  a_r4_word_stable: assert property (@(posedge clk) disable iff (!rstN || !pdN)
    (ctl.busActive && !ctl.pop) |=> $stable(curWord));

  a_r7_one_select: assert property (@(posedge clk) disable iff (!rstN)
    pdN |-> (busCs1N || busCs2N));
endmodule

// File: rtl/slv_frame_rx.sv
module slv_frame_rx
  import slv_wr_pkg::*;
#(
  parameter int QDEPTH    = 4,
  parameter int SETUP_CYC = 1,
  parameter int LOW_CYC   = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdN,
  input  logic              modeI80,
  input  logic [LANES-1:0]  laneIn,
  input  logic              refClkIn,
  output logic              busAd,
  output logic [WORD_W-1:0] busData,
  output logic              busDataOe,
  output logic              busCs1N,
  output logic              busCs2N,
  output logic              busMf0,
  output logic              busMf1,
  output logic              clkOut,
  output logic              readReq,
  output logic              readAd,
  output logic              readToCs1
);
  ctrl_t            ctl;
  logic [LANES-1:0] pairRise;
  logic             qEmpty;

  slv_wr_ctrl #(.SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .pdN(pdN), .pairRise(pairRise), .qEmpty(qEmpty), .ctl(ctl));

  slv_wr_dp #(.QDEPTH(QDEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .pdN(pdN), .modeI80(modeI80), .laneIn(laneIn),
    .refClkIn(refClkIn), .ctl(ctl), .pairRise(pairRise), .qEmpty(qEmpty),
    .busData(busData), .busAd(busAd), .busDataOe(busDataOe), .busCs1N(busCs1N),
    .busCs2N(busCs2N), .busMf0(busMf0), .busMf1(busMf1), .clkOut(clkOut),
    .readReq(readReq), .readAd(readAd), .readToCs1(readToCs1));
endmodule

// File: tb/slv_frame_rx_tb.sv
module slv_frame_rx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0, pdN = 1'b1, modeI80 = 1'b1, refClkIn = 1'b1;
  logic [1:0] laneIn = 2'b00;
  logic busAd, busDataOe, busCs1N, busCs2N, busMf0, busMf1, clkOut;
  logic readReq, readAd, readToCs1;
  logic [15:0] busData;

  int nChecks = 0, nFail = 0, cycleCnt = 0;
  logic [24:0] snap [2048];

  always #5 clk = ~clk;

  slv_frame_rx dut_i (
    .clk(clk), .rstN(rstN), .pdN(pdN), .modeI80(modeI80), .laneIn(laneIn),
    .refClkIn(refClkIn), .busAd(busAd), .busData(busData), .busDataOe(busDataOe),
    .busCs1N(busCs1N), .busCs2N(busCs2N), .busMf0(busMf0), .busMf1(busMf1),
    .clkOut(clkOut), .readReq(readReq), .readAd(readAd), .readToCs1(readToCs1));

  always @(posedge clk) cycleCnt <= cycleCnt + 1;
  // snapshot layout: 24 readToCs1, 23 readAd, 22 readReq, 21 ad, 20 oe,
  // 19 cs1n, 18 cs2n, 17 mf0, 16 mf1, 15:0 data
  always @(negedge clk)
    snap[cycleCnt % 2048] <= {readToCs1, readAd, readReq, busAd, busDataOe,
                              busCs1N, busCs2N, busMf0, busMf1, busData};

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic laneIdle();
    @(negedge clk); #1 laneIn = 2'b00;
  endtask

  task automatic sendFrame(input bit rw, input bit ad, input bit sel,
                           input logic [15:0] d, output int s);
    @(negedge clk); #1 laneIn = {rw, 1'b1};
    @(posedge clk); #1 s = cycleCnt; laneIn = {sel, ad};
    if (!rw) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); #1 laneIn = {d[8+2*k], d[2*k]};
        @(posedge clk); #1 laneIn = {d[9+2*k], d[2*k+1]};
      end
    end
  endtask

  task automatic waitCycle(input int c);
    while (cycleCnt <= c) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkWrite(input int s, input bit ad, input bit sel,
                            input logic [15:0] d, input bit i80,
                            input bit chkPre, input bit chkPost);
    logic [24:0] sn;
    waitCycle(s + 11);
    for (int c = 6; c <= 10; c++) begin
      bit low;
      logic selCs, othCs;
      low = (c >= 7 && c <= 9);
      sn = snap[(s + c) % 2048];
      selCs = sel ? sn[19] : sn[18];
      othCs = sel ? sn[18] : sn[19];
      chk("R4 data driven in window", int'(sn[20]), 1);
      chk("R2 replayed word", int'(sn[15:0]), int'(d));
      chk("R7 address/data out", int'(sn[21]), int'(ad));
      chk("R7 unselected cs high", int'(othCs), 1);
      chk("R5 R6 mf0 high", int'(sn[17]), 1);
      if (i80) begin
        chk("R3 R5 write strobe", int'(sn[16]), int'(!low));
        chk("R5 R7 selected cs low", int'(selCs), 0);
      end else begin
        chk("R3 R6 cs strobe", int'(selCs), int'(!low));
        chk("R6 read/write low", int'(sn[16]), 0);
      end
    end
    if (chkPre) begin
      sn = snap[(s + 5) % 2048];
      chk("R4 not driven before window", int'(sn[20]), 0);
    end
    if (chkPost) begin
      sn = snap[(s + 11) % 2048];
      chk("R4 released after hold", int'(sn[20]), 0);
      chk("R4 data zero after release", int'(sn[15:0]), 0);
      chk("R1 cs idle after write", int'(sn[19:18]), 3);
      chk("R1 mf1 idle after write", int'(sn[16]), 1);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 reset cs1n", int'(busCs1N), 1);
    chk("R1 reset cs2n", int'(busCs2N), 1);
    chk("R1 reset mf0", int'(busMf0), 1);
    chk("R1 reset mf1", int'(busMf1), 1);
    chk("R1 reset oe", int'(busDataOe), 0);
    chk("R1 reset data", int'(busData), 0);
  endtask

  task automatic testI80Single();
    int s;
    modeI80 = 1'b1;
    sendFrame(1'b0, 1'b1, 1'b1, 16'hA5C3, s); laneIdle();
    checkWrite(s, 1'b1, 1'b1, 16'hA5C3, 1'b1, 1'b1, 1'b1);
    sendFrame(1'b0, 1'b0, 1'b0, 16'h8001, s); laneIdle();
    checkWrite(s, 1'b0, 1'b0, 16'h8001, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testM68();
    int s;
    @(negedge clk); modeI80 = 1'b0;
    sendFrame(1'b0, 1'b1, 1'b1, 16'h3C5A, s); laneIdle();
    checkWrite(s, 1'b1, 1'b1, 16'h3C5A, 1'b0, 1'b1, 1'b1);
    sendFrame(1'b0, 1'b0, 1'b0, 16'hFFFE, s); laneIdle();
    checkWrite(s, 1'b0, 1'b0, 16'hFFFE, 1'b0, 1'b1, 1'b1);
    @(negedge clk); modeI80 = 1'b1;
  endtask

  task automatic testBackToBack();
    int s1, s2, s3;
    sendFrame(1'b0, 1'b1, 1'b1, 16'h1234, s1);
    sendFrame(1'b0, 1'b0, 1'b0, 16'hBEEF, s2);
    sendFrame(1'b0, 1'b1, 1'b0, 16'h0F0F, s3);
    laneIdle();
    // R9: each window checked against its own frame start
    checkWrite(s1, 1'b1, 1'b1, 16'h1234, 1'b1, 1'b1, 1'b0);
    checkWrite(s2, 1'b0, 1'b0, 16'hBEEF, 1'b1, 1'b0, 1'b0);
    checkWrite(s3, 1'b1, 1'b0, 16'h0F0F, 1'b1, 1'b0, 1'b1);
    chk("R9 frames abut", s2 - s1, 5);
  endtask

  task automatic testRead();
    int s;
    logic [24:0] sn;
    sendFrame(1'b1, 1'b1, 1'b0, 16'h0000, s); laneIdle();
    waitCycle(s + 12);
    chk("R10 read request pulse", int'(snap[(s + 1) % 2048][22]), 1);
    chk("R10 read flag", int'(snap[(s + 1) % 2048][23]), 1);
    chk("R10 read select", int'(snap[(s + 1) % 2048][24]), 0);
    chk("R10 pulse one cycle", int'(snap[(s + 2) % 2048][22]), 0);
    for (int c = 0; c <= 12; c++) begin
      sn = snap[(s + c) % 2048];
      chk("R10 no bus drive on read", int'(sn[20]), 0);
      chk("R10 no select on read", int'(sn[19:18]), 3);
    end
  endtask

  task automatic testPowerDown();
    int s;
    for (int m = 1; m >= 0; m--) begin
      @(negedge clk); modeI80 = m[0]; pdN = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 pd ad high", int'(busAd), 1);
      chk("R8 pd data low", int'(busData), 0);
      chk("R8 pd data driven", int'(busDataOe), 1);
      chk("R8 pd clkOut low", int'(clkOut), 0);
      chk("R8 pd cs1n high", int'(busCs1N), 1);
      chk("R8 pd cs2n by mode", int'(busCs2N), m == 1 ? 0 : 1);
      chk("R8 pd mf0 high", int'(busMf0), 1);
      chk("R8 pd mf1 high", int'(busMf1), 1);
      pdN = 1'b1;
      @(negedge clk);
      chk("R8 clkOut follows ref", int'(clkOut), 1);
      chk("R1 idle after pd oe", int'(busDataOe), 0);
      chk("R1 idle after pd cs", int'({busCs1N, busCs2N}), 3);
    end
    modeI80 = 1'b1;
    sendFrame(1'b0, 1'b1, 1'b0, 16'h5A5A, s); laneIdle();
    checkWrite(s, 1'b1, 1'b0, 16'h5A5A, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testI80Single();
    testM68();
    testBackToBack();
    testRead();
    testPowerDown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule